// File: doc/BRIEF.md
# Burst column address generator

This block turns one burst request into the run of column addresses that the burst visits, one address per data beat. A request carries a starting column, a three-bit length code and an ordering bit. These are the burst-length and burst-type fields of the memory's mode word. The block then steps through an aligned group of columns whose size equals the burst length. The bits above that group stay fixed, and the bits inside it wrap rather than carry outward.

Two orderings are offered. Sequential ordering adds the beat number to the low bits of the start, modulo the length. Interleaved ordering XORs the beat number into the low bits. A request that uses a reserved length code produces a one-cycle error pulse and no beats.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `beat_vld_o`, `last_o` and `err_o` are 0 after that edge.
- R2: The length code sets the beat count: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. `last_o` is 1 only on the final beat.
- R3: A request with any other length code (3'b000 or 3'b1xx) raises `err_o` for exactly the one cycle after the request, and produces no beats.
- R4: When `ilv_i` is 0 (sequential), beat n carries low bits (start_low + n) mod BL. Here start_low is the start column modulo BL, and the column bits at BL and above equal those of the start column.
- R5: When `ilv_i` is 1 (interleaved), beat n carries low bits start_low XOR n, and the column bits at BL and above equal those of the start column.
- R6: A request is taken at a clock edge where `start_i` is 1 and no burst is running. Beat 0 appears in the next cycle, and its column equals the start column.
- R7: Beats follow one per cycle with no gap. `beat_vld_o` is 0 in the cycle after `last_o`, and a request made in that cycle is accepted.
- R8: A request made while a burst is running is ignored and does not change the running burst's addresses or length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | COL_W | Starting column of the burst |
| len_code_i | input | 3 | Burst-length code from the mode word |
| ilv_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented in this cycle |
| last_o | output | 1 | The current beat is the final one of the burst |
| err_o | output | 1 | A request used a reserved length code |

## Verification
The bench builds the block with COL_W = 6, so the 64 possible start columns can be swept for every legal length and both orderings. This covers every low-bit offset inside every aligned group, and it also covers groups at the top and bottom of the column range. Each beat is compared with an arithmetic model. Each burst is started in the idle cycle that follows the previous last beat. Every reserved code is applied with both ordering values. A request made in the middle of a burst checks that the running burst is left unchanged.

// File: rtl/burst_col_pkg.sv
// Package: shared constants and helpers for the burst column generator.
// Assumes bursts never exceed 8 beats, so a 3-bit beat index suffices.
package burst_col_pkg;

    localparam int BEAT_W = 3;   // beat index width (max 8 beats)
    localparam int LG_W   = 2;   // width of log2(burst length)
    localparam int CODE_W = 3;   // mode-word length code width

    // Legal length codes; every other value is reserved.
    typedef enum logic [CODE_W-1:0] {
        BLEN_2 = 3'b001,
        BLEN_4 = 3'b010,
        BLEN_8 = 3'b011
    } blen_code_e;

    // Mask that selects the low index bits covered by a burst of 2**lg.
    function automatic logic [BEAT_W-1:0] beat_mask(input logic [LG_W-1:0] lg);
        logic [BEAT_W:0] one_hot;
        one_hot   = {{BEAT_W{1'b0}}, 1'b1} << lg;
        beat_mask = one_hot[BEAT_W-1:0] - 1'b1;
    endfunction

endpackage

// File: rtl/bcg_len_decode.sv
// Module: bcg_len_decode
// Maps the 3-bit length code to log2 of the burst length and a legality flag.
// Assumes nothing about timing; purely combinational.
module bcg_len_decode
    import burst_col_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              ok_o,
    output logic [LG_W-1:0]   lg_o
);

    // Decode legal codes; reserved codes give ok_o = 0.
    always_comb begin
        ok_o = 1'b1;
        lg_o = '0;
        case (code_i)
            BLEN_2:  lg_o = 2'd1;
            BLEN_4:  lg_o = 2'd2;
            BLEN_8:  lg_o = 2'd3;
            default: ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcg_beat_ctrl.sv
// Module: bcg_beat_ctrl
// Holds the burst state: running flag, beat index and latched request.
// Assumes a request is only taken when idle; requests while running are dropped.
module bcg_beat_ctrl
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              code_ok_i,
    input  logic [LG_W-1:0]   lg_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              ilv_i,
    output logic              busy_o,
    output logic [BEAT_W-1:0] idx_o,
    output logic [LG_W-1:0]   lg_o,
    output logic [COL_W-1:0]  base_o,
    output logic              ilv_o,
    output logic              last_o,
    output logic              err_o
);

    logic take;
    logic busy_q, ilv_q, err_q;
    logic [BEAT_W-1:0] idx_q;
    logic [LG_W-1:0]   lg_q;
    logic [COL_W-1:0]  base_q;

    // Request accepted only while idle.
    always_comb take = start_i && !busy_q;

    // Final beat: index reached the burst-length mask.
    always_comb last_o = busy_q && (idx_q == beat_mask(lg_q));

    // Running flag and beat index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (take && code_ok_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (last_o) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (busy_q) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Latch the request fields for the duration of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lg_q   <= '0;
            base_q <= '0;
            ilv_q  <= 1'b0;
        end else if (take && code_ok_i) begin
            lg_q   <= lg_i;
            base_q <= col_i;
            ilv_q  <= ilv_i;
        end
    end

    // One-cycle error pulse for a reserved length code.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= take && !code_ok_i;
    end

    assign busy_o = busy_q;
    assign idx_o  = idx_q;
    assign lg_o   = lg_q;
    assign base_o = base_q;
    assign ilv_o  = ilv_q;
    assign err_o  = err_q;

endmodule

// File: rtl/bcg_col_order.sv
// Module: bcg_col_order
// Forms the beat column: low bits inside the aligned group follow the chosen
// ordering, bits above the group copy the base column. Combinational.
// Assumes COL_W > BEAT_W.
module bcg_col_order
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] idx_i,
    input  logic [LG_W-1:0]   lg_i,
    input  logic              ilv_i,
    output logic [COL_W-1:0]  col_o
);

    logic [BEAT_W-1:0] mixed;

    // Sequential adds (wrapping mod 8, low bits valid mod BL); interleaved XORs.
    always_comb mixed = ilv_i ? (base_i[BEAT_W-1:0] ^ idx_i)
                              : (base_i[BEAT_W-1:0] + idx_i);

    // Per-bit select: inside the group take the mixed bit, else keep base.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < BEAT_W) begin : g_low
            assign col_o[i] = (i < int'(lg_i)) ? mixed[i] : base_i[i];
        end else begin : g_high
            assign col_o[i] = base_i[i];
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Emits one column per beat for a 2/4/8-beat burst with wrap inside the
// aligned group, sequential or interleaved. Reserved codes give err_o.
// Assumes COL_W >= 4.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o,
    output logic             err_o
);

    logic              code_ok;
    logic [LG_W-1:0]   lg_req, lg_cur;
    logic [BEAT_W-1:0] idx;
    logic [COL_W-1:0]  base;
    logic              ilv_cur, busy;

    bcg_len_decode u_dec (
        .code_i (len_code_i),
        .ok_o   (code_ok),
        .lg_o   (lg_req)
    );

    bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .code_ok_i (code_ok),
        .lg_i      (lg_req),
        .col_i     (start_col_i),
        .ilv_i     (ilv_i),
        .busy_o    (busy),
        .idx_o     (idx),
        .lg_o      (lg_cur),
        .base_o    (base),
        .ilv_o     (ilv_cur),
        .last_o    (last_o),
        .err_o     (err_o)
    );

    bcg_col_order #(.COL_W(COL_W)) u_ord (
        .base_i (base),
        .idx_i  (idx),
        .lg_i   (lg_cur),
        .ilv_i  (ilv_cur),
        .col_o  (col_o)
    );

    assign beat_vld_o = busy;

endmodule

// File: rtl/bcg_check.sv
// Module: bcg_check
// Protocol checker for burst_col_gen, attached by bind below.
module bcg_check #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             ilv_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o,
    input logic             err_o
);

    // Final-beat flag only on a presented beat.
    assert_last_in_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);

    // Error pulse never coincides with a beat and lasts one cycle.
    assert_err_no_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !beat_vld_o);
    assert_err_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // Group bits above the widest burst stay put within a burst.
    assert_upper_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && $past(beat_vld_o) && !$past(last_o)) |->
            $stable(col_o[COL_W-1:3]));

    // First beat carries the requested start column.
    assert_first_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_vld_o) |-> (col_o == $past(start_col_i)));

    // Gap after the final beat.
    assert_gap_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !beat_vld_o);

    // Beats are contiguous until the final beat.
    assert_no_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !last_o) |=> beat_vld_o);

endmodule

bind burst_col_gen bcg_check #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .ilv_i       (ilv_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;

    localparam int COL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o, last_o, err_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .col_o(col_o),
        .beat_vld_o(beat_vld_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int expect_col(int start, int lg, bit ilv, int n);
        int bl  = 1 << lg;
        int lo  = start & (bl - 1);
        int off = ilv ? (lo ^ n) : ((lo + n) % bl);
        return (start & ~(bl - 1)) | off;
    endfunction

    // Issue a request at a negedge; caller is at a negedge.
    task automatic run_burst(input int col, input int lg, input bit ilv);
        string rq = ilv ? "R5" : "R4";
        start_i = 1'b1; start_col_i = COL_W'(col);
        len_code_i = 3'(lg); ilv_i = ilv;   // codes 1,2,3 equal lg
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < (1 << lg); n++) begin
            check("R7 beat valid", int'(beat_vld_o), 1);
            check(rq, int'(col_o), expect_col(col, lg, ilv, n));
            check("R2 last flag", int'(last_o), (n == (1 << lg) - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R7 gap after last", int'(beat_vld_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 beat_vld reset", int'(beat_vld_o), 0);
        check("R1 last reset", int'(last_o), 0);
        check("R1 err reset", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R6 R7: every start column, length and ordering, back to back.
        for (int ilv = 0; ilv < 2; ilv++)
            for (int lg = 1; lg <= 3; lg++)
                for (int c = 0; c < (1 << COL_W); c++)
                    run_burst(c, lg, 1'(ilv));

        // R6: first beat equals start column (explicit case).
        start_i = 1'b1; start_col_i = 6'd45; len_code_i = 3'b011; ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 first beat col", int'(col_o), 45);
        repeat (8) @(negedge clk);

        // R3: every reserved code with both orderings.
        for (int ilv = 0; ilv < 2; ilv++)
            for (int code = 0; code < 8; code++) begin
                if (code >= 1 && code <= 3) continue;
                start_i = 1'b1; start_col_i = 6'd13;
                len_code_i = 3'(code); ilv_i = 1'(ilv);
                @(negedge clk);
                start_i = 1'b0;
                check("R3 err pulse", int'(err_o), 1);
                check("R3 no beat", int'(beat_vld_o), 0);
                @(negedge clk);
                check("R3 err cleared", int'(err_o), 0);
                check("R3 still no beat", int'(beat_vld_o), 0);
            end

        // R8: request during a running burst is ignored.
        start_i = 1'b1; start_col_i = 6'd21; len_code_i = 3'b011; ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < 8; n++) begin
            if (n == 2) begin
                start_i = 1'b1; start_col_i = 6'd50; len_code_i = 3'b001; ilv_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            check("R8 col unchanged", int'(col_o), expect_col(21, 3, 1'b0, n));
            check("R8 length unchanged", int'(last_o), (n == 7) ? 1 : 0);
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R8 idle after burst", int'(beat_vld_o), 0);
        @(negedge clk);
        check("R8 no late start", int'(beat_vld_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule